// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Controller

This controller sits between a running synthesized source clock and two gated output clocks, a main clock and a reference clock. An asynchronous active-low power-down pin requests that every output be stopped. The request passes through a two-stage synchronizer and is applied only while the source clock is low, so every output pulse keeps its full width. After both outputs are parked, the controller raises a power-down line to the oscillator and PLL.

When the pin is released, the oscillator power-down line drops at once. A stabilization counter of `STABLE_CYC` source cycles then starts. The outputs stay stopped until the counter completes. If the pin is asserted again, the counter starts over. Each output also has its own enable bit, which stops only that output and leaves the oscillator running. A stopped output is either released to high impedance or driven low, as a shared tri-state register bit selects.

Top module: `clkstop_ctrl`

## Requirements
- R1: The power-down pin (`pwr_dn_n`, 0 = power down) is synchronized by two source-clock stages. When the pin falls just after rising edge k, the outputs still give full high phases after edges k+1 and k+2, and stay low from edge k+3 onward.
- R2: While the synchronized power-down request is active, both output clocks are held low and `osc_pd_o` is 1 from the edge after both outputs have stopped.
- R3: Every high phase on an output clock starts on a rising edge of the source clock and lasts exactly one source high phase. No shortened pulse or extra edge appears when stopping or restarting.
- R4: When the pin rises just after edge k, both outputs stay low through edge k+STABLE_CYC+2. An enabled output gives its first high phase after edge k+STABLE_CYC+3. After reset release, the first high phase follows edge STABLE_CYC+1.
- R5: Reasserting power-down while the stabilization counter is running clears the counter. A later release waits the full interval again.
- R6: Output-enable (1 = drive) is 1 for a running output. For a stopped output it is 0 when `tri_en` = 1 (high impedance) and 1 when `tri_en` = 0, in which case the output is driven low.
- R7: An enable bit (`main_en`, `ref_en`; 1 = enabled) cleared just after edge k stops only its own output from the high phase after edge k+1. It does not assert `osc_pd_o`. Setting the bit again restarts the output on a full pulse.
- R8: `osc_pd_o` rises one edge after both outputs are stopped under a power-down request. For a pin released after edge k, it is still 1 after edge k+2 and is 0 after edge k+3.
- R9: During reset, both output clocks are low, both output-enables are 1 when `tri_en` = 0, and `osc_pd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Running synthesized source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down pin |
| main_en | input | 1 | Main clock enable bit, 1 = enabled |
| ref_en | input | 1 | Reference clock enable bit, 1 = enabled |
| tri_en | input | 1 | 1 = stopped outputs go high impedance, 0 = driven low |
| main_clk_o | output | 1 | Gated main clock |
| main_oe_o | output | 1 | Main output driver enable |
| ref_clk_o | output | 1 | Gated reference clock |
| ref_oe_o | output | 1 | Reference output driver enable |
| osc_pd_o | output | 1 | Power-down to oscillator and PLL |

## Verification
A per-output enable change and a power-down transition can land in the same cycle. Both then act on the same low-phase gating flop, and a wrong merge would clip a pulse or assert the oscillator power-down too early. The bench provokes this by randomizing both enable bits and `tri_en` in the same cycle that the pin falls or rises, and by toggling enables throughout the stabilization wait. Each cycle is judged against expected clock, output-enable and oscillator levels derived from R1, R4, R6, R7 and R8. A pulse-width monitor on both outputs also measures every high phase.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
    localparam int unsigned NUM_OUT  = 2;
    localparam int unsigned IDX_MAIN = 0;
    localparam int unsigned IDX_REF  = 1;

    typedef struct packed {
        logic osc_pd;
    } ctrl_state_t;
endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic req
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], ~pin_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign req = sh_q[STAGES-1];
endmodule

// File: rtl/clkstop_timer.sv
`timescale 1ns/1ps
module clkstop_timer #(
    parameter int unsigned STABLE_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic ready
);
    localparam int unsigned CW = $clog2(STABLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STABLE_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hold)                cnt_d = '0;
        else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == LIMIT);
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tri_en,
    output logic gclk,
    output logic oe,
    output logic stopped
);
    logic en_d, en_q;

    always_comb begin
        en_d = run;
    end

    // Enable only moves on the falling edge, while clk is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign gclk    = clk & en_q;
    assign stopped = ~en_q;
    assign oe      = en_q | ~tri_en;
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int unsigned STABLE_CYC  = 1024,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic pwr_dn_n,
    input  logic main_en,
    input  logic ref_en,
    input  logic tri_en,
    output logic main_clk_o,
    output logic main_oe_o,
    output logic ref_clk_o,
    output logic ref_oe_o,
    output logic osc_pd_o
);
    logic               pd_req;
    logic               ready;
    logic [NUM_OUT-1:0] en_vec, run, stopped, gclk, oe;
    ctrl_state_t        st_d, st_q;

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .pin_n (pwr_dn_n),
        .req   (pd_req)
    );

    clkstop_timer #(.STABLE_CYC(STABLE_CYC)) u_timer (
        .clk   (clk_src),
        .rst_n (rst_n),
        .hold  (pd_req),
        .ready (ready)
    );

    always_comb begin
        en_vec           = '0;
        en_vec[IDX_MAIN] = main_en;
        en_vec[IDX_REF]  = ref_en;
        run              = en_vec & {NUM_OUT{ready & ~pd_req}};
        st_d             = st_q;
        st_d.osc_pd      = pd_req & (st_q.osc_pd | (&stopped));
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        clkstop_gate u_gate (
            .clk     (clk_src),
            .rst_n   (rst_n),
            .run     (run[g]),
            .tri_en  (tri_en),
            .gclk    (gclk[g]),
            .oe      (oe[g]),
            .stopped (stopped[g])
        );
    end

    assign main_clk_o = gclk[IDX_MAIN];
    assign main_oe_o  = oe[IDX_MAIN];
    assign ref_clk_o  = gclk[IDX_REF];
    assign ref_oe_o   = oe[IDX_REF];
    assign osc_pd_o   = st_q.osc_pd;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_req,
    input logic       ready,
    input logic [1:0] stopped,
    input logic       main_en,
    input logic       ref_en,
    input logic       tri_en,
    input logic       main_oe_o,
    input logic       ref_oe_o,
    input logic       osc_pd_o
);
    p_pd_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |-> (stopped == 2'b11));

    p_hold_until_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (stopped == 2'b11));

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |=> !ready);

    p_tristate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_pd_o && tri_en) |-> (!main_oe_o && !ref_oe_o));

    p_main_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !main_en |-> stopped[0]);

    p_ref_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |-> stopped[1]);

    p_osc_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_pd_o) |-> ($past(stopped) == 2'b11));

    p_osc_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_req |=> !osc_pd_o);
endmodule

bind clkstop_ctrl clkstop_ctrl_chk u_chk (
    .clk       (clk_src),
    .rst_n     (rst_n),
    .pd_req    (pd_req),
    .ready     (ready),
    .stopped   (stopped),
    .main_en   (main_en),
    .ref_en    (ref_en),
    .tri_en    (tri_en),
    .main_oe_o (main_oe_o),
    .ref_oe_o  (ref_oe_o),
    .osc_pd_o  (osc_pd_o)
);

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb;
    localparam int S = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_dn_n = 1'b1;
    logic main_en = 1'b1, ref_en = 1'b1, tri_en = 1'b0;
    logic main_clk_o, main_oe_o, ref_clk_o, ref_oe_o, osc_pd_o;

    int n_chk = 0, n_bad = 0, glitches = 0;
    bit done = 0;
    realtime t_main = 0, t_ref = 0;

    always #4 clk = ~clk;

    clkstop_ctrl #(.STABLE_CYC(S)) u_dut (
        .clk_src(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n),
        .main_en(main_en), .ref_en(ref_en), .tri_en(tri_en),
        .main_clk_o(main_clk_o), .main_oe_o(main_oe_o),
        .ref_clk_o(ref_clk_o), .ref_oe_o(ref_oe_o), .osc_pd_o(osc_pd_o)
    );

    // R3 pulse monitor
    always @(posedge main_clk_o) begin
        t_main = $realtime;
        if (clk !== 1'b1) glitches++;
    end
    always @(negedge main_clk_o) if ($realtime - t_main != 4.0) glitches++;
    always @(posedge ref_clk_o) begin
        t_ref = $realtime;
        if (clk !== 1'b1) glitches++;
    end
    always @(negedge ref_clk_o) if ($realtime - t_ref != 4.0) glitches++;

    function automatic logic exp_clk(input logic running, input logic en);
        return running & en;
    endfunction

    function automatic logic exp_oe(input logic running, input logic en, input logic tr);
        return (running & en) ? 1'b1 : ~tr;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(input string req, input logic running, input logic osc);
        check(req, main_clk_o, exp_clk(running, main_en));
        check(req, ref_clk_o,  exp_clk(running, ref_en));
        check({req, "/R6"}, main_oe_o, exp_oe(running, main_en, tri_en));
        check({req, "/R6"}, ref_oe_o,  exp_oe(running, ref_en, tri_en));
        check({req, "/R8"}, osc_pd_o, osc);
    endtask

    task automatic release_check(input bit rnd);
        pwr_dn_n = 1'b1;
        for (int i = 1; i <= S + 3; i++) begin
            tick();
            check_all(i <= S + 2 ? "R4" : "R4_run", i > S + 2, i <= 2);
            if (rnd && i < S + 2) begin
                main_en = 1'($urandom); ref_en = 1'($urandom); tri_en = 1'($urandom);
            end
        end
    endtask

    task automatic pd_cycle(input int len, input bit rnd);
        if (rnd) begin
            main_en = 1'($urandom); ref_en = 1'($urandom); tri_en = 1'($urandom);
        end
        pwr_dn_n = 1'b0;
        for (int i = 1; i <= len; i++) begin
            tick();
            check_all(i <= 2 ? "R1" : "R2", i <= 2, i >= 3);
        end
        release_check(rnd);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #13;
        check("R9", main_clk_o, 1'b0);
        check("R9", ref_clk_o, 1'b0);
        check("R9", main_oe_o, 1'b1);
        check("R9", ref_oe_o, 1'b1);
        check("R9", osc_pd_o, 1'b0);
        tick();
        rst_n = 1'b1;
        for (int i = 1; i <= S + 1; i++) begin
            tick();
            check_all("R4_reset", i == S + 1, 1'b0);
        end

        // R1 R2 R8 directed, driven-low stop
        pd_cycle(10, 0);
        // R6 tri-state stop
        tri_en = 1'b1;
        pd_cycle(6, 0);
        tri_en = 1'b0;

        // R5 restart of the stabilization interval
        pwr_dn_n = 1'b0;
        for (int i = 1; i <= 5; i++) tick();
        pwr_dn_n = 1'b1;
        for (int i = 1; i <= S / 2; i++) begin
            tick();
            check_all("R5", 1'b0, i <= 2);
        end
        pwr_dn_n = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            tick();
            check_all("R5", 1'b0, i >= 3);
        end
        release_check(0);

        // R7 per-output enable
        main_en = 1'b0;
        tick();
        check_all("R7", 1'b1, 1'b0);
        tick();
        check_all("R7", 1'b1, 1'b0);
        main_en = 1'b1; ref_en = 1'b0; tri_en = 1'b1;
        tick();
        check_all("R7", 1'b1, 1'b0);
        ref_en = 1'b1; tri_en = 1'b0;
        tick();
        check_all("R7", 1'b1, 1'b0);

        for (int it = 0; it < 300; it++) begin
            if (($urandom % 4) == 0) begin
                pd_cycle(3 + int'($urandom % 10), 1);
            end else begin
                main_en = 1'($urandom); ref_en = 1'($urandom); tri_en = 1'($urandom);
                tick();
                check_all("R7_rnd", 1'b1, 1'b0);
            end
        end

        tick();
        check("R3", glitches != 0, 1'b0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule